// File: doc/BRIEF.md
# CTS-Gated Transmit Controller

This block decides when the next character may move from a transmit queue into a UART transmit shifter, honouring the remote receiver's Clear-To-Send line. It watches the queue's not-empty flag and the shifter's idle flag and emits a one-cycle load strobe when a new frame may begin. The block has no way to abort a frame. When automatic CTS control is switched on, a high CTS level withholds the next load. The character already on the wire therefore always runs through its stop bit, and sending stops at the next character boundary.

The CTS pin is asynchronous, so it passes through a two-flop synchroniser before any decision is made. A rising edge of the synchronised CTS is a stop request. That edge latches a sticky status flag when both the automatic-control enable and the flow-interrupt enable are on. The flag holds until the host pulses a clear. The shift register, the baud-rate timing and the FIFO storage belong to neighbouring blocks.

Top module: `cts_tx_gate`

## Requirements
- R1: After reset `cts_status` is 0 and the synchroniser holds CTS low, so a load is permitted in the first cycle after reset even if `cts_in` was high during reset.
- R2: `load_strobe` is 1 only in a cycle where `shifter_idle` and `fifo_nempty` are both 1; with `auto_cts_en` at 0 the level of CTS has no effect on it.
- R3: With `auto_cts_en` at 1, a high synchronised CTS withholds `load_strobe`. `cts_in` reaches the gate after two rising clock edges, so a load resumes two edges after `cts_in` returns to 0.
- R4: `load_strobe` is never 1 in two consecutive cycles, which gives the shifter one cycle to drop `shifter_idle`.
- R5: A 0-to-1 change of the synchronised CTS sets `cts_status` on the third rising edge after `cts_in` rises, and only when `auto_cts_en` and `flow_irq_en` are both 1.
- R6: Once set, `cts_status` stays 1 until `status_clr` is sampled high, and it then reads 0 after that edge.
- R7: When a new set event and `status_clr` fall on the same edge, the set wins and `cts_status` stays 1.
- R8: A CTS pulse that rises and falls again while the shifter is busy leaves no gap: once CTS has settled low, the load strobe appears as soon as the shifter reports idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_in | input | 1 | Asynchronous Clear-To-Send line, 1 means stop |
| auto_cts_en | input | 1 | Enables automatic CTS gating |
| flow_irq_en | input | 1 | Enables latching of the CTS-change status |
| fifo_nempty | input | 1 | Transmit queue holds at least one character |
| shifter_idle | input | 1 | Shifter has finished its stop bit and is free |
| status_clr | input | 1 | Host clear pulse for `cts_status` |
| load_strobe | output | 1 | One-cycle request to load the next character |
| cts_status | output | 1 | Sticky flag for a CTS stop request |

## Verification
The two functions that can collide in one cycle are the latching of a fresh CTS edge into the status flag and the host's clear of that flag. The bench raises `cts_in` and then places the `status_clr` pulse on the third rising edge after the rise, which is the edge on which the set lands. It requires the flag to read 1 afterwards, and it requires a separate clear with no pending edge to drop the flag to 0. The load gate gets a full sweep over enable, CTS, queue and idle levels. Each expected strobe comes from the product of those levels.

// File: rtl/cts_tx_gate.sv
module cts_tx_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_in,
  input  logic auto_cts_en,
  input  logic flow_irq_en,
  input  logic fifo_nempty,
  input  logic shifter_idle,
  input  logic status_clr,
  output logic load_strobe,
  output logic cts_status
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic cts_s;
  logic cts_d;
  logic load_q;
  logic cts_rise;
  logic status_set;
  logic may_send;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_in};
  end

  assign cts_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_d <= 1'b0;
    else        cts_d <= cts_s;
  end

  assign cts_rise   = cts_s & ~cts_d;
  assign status_set = cts_rise & auto_cts_en & flow_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cts_status <= 1'b0;
    else if (status_set) cts_status <= 1'b1;
    else if (status_clr) cts_status <= 1'b0;
  end

  assign may_send    = ~auto_cts_en | ~cts_s;
  assign load_strobe = shifter_idle & fifo_nempty & may_send & ~load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= load_strobe;
  end

endmodule

module cts_tx_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_cts_en,
  input logic flow_irq_en,
  input logic fifo_nempty,
  input logic shifter_idle,
  input logic status_clr,
  input logic load_strobe,
  input logic cts_status,
  input logic cts_sync
);

  p_load_needs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> (shifter_idle && fifo_nempty));

  p_cts_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && cts_sync) |-> !load_strobe);

  p_no_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> !load_strobe);

  p_status_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_status) |-> $past(auto_cts_en && flow_irq_en));

  p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_status && !status_clr) |=> cts_status);

  p_status_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !auto_cts_en) |=> !cts_status);

endmodule

bind cts_tx_gate cts_tx_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .flow_irq_en(flow_irq_en),
  .fifo_nempty(fifo_nempty), .shifter_idle(shifter_idle), .status_clr(status_clr),
  .load_strobe(load_strobe), .cts_status(cts_status), .cts_sync(cts_s)
);

// File: tb/test_cts_tx_gate.sv
module test_cts_tx_gate;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_in = 1'b0, auto_cts_en = 1'b0, flow_irq_en = 1'b0;
  logic fifo_nempty = 1'b0, shifter_idle = 1'b0, status_clr = 1'b0;
  logic load_strobe, cts_status;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cts_tx_gate i_cts_tx_gate (
    .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .auto_cts_en(auto_cts_en),
    .flow_irq_en(flow_irq_en), .fifo_nempty(fifo_nempty), .shifter_idle(shifter_idle),
    .status_clr(status_clr), .load_strobe(load_strobe), .cts_status(cts_status)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_status();
    status_clr = 1'b1;
    tick(1);
    status_clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic exp;
    cts_in = 1'b1; auto_cts_en = 1'b1;
    tick(3);
    #1;
    chk(cts_status, 1'b0, "R1 status in reset");
    rst_n = 1'b1;
    fifo_nempty = 1'b1; shifter_idle = 1'b1;
    #1;
    chk(load_strobe, 1'b1, "R1 load allowed right after reset");
    tick(1);
    shifter_idle = 1'b0; cts_in = 1'b0;
    tick(4);
    #1;
    chk(cts_status, 1'b0, "R1 no status without irq enable");

    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 2; c++)
        for (int f = 0; f < 2; f++)
          for (int i = 0; i < 2; i++) begin
            auto_cts_en = a[0]; cts_in = c[0]; fifo_nempty = f[0]; shifter_idle = 1'b0;
            tick(3);
            shifter_idle = i[0];
            exp = i[0] & f[0] & (~a[0] | ~c[0]);
            #1;
            chk(load_strobe, exp, (a == 1) ? "R3 gate sweep" : "R2 gate sweep");
            tick(1);
            #1;
            if (exp) chk(load_strobe, 1'b0, "R4 no back-to-back strobe");
            tick(1);
            #1;
            chk(load_strobe, exp, "R2 strobe after gap");
            shifter_idle = 1'b0;
          end

    auto_cts_en = 1'b1; fifo_nempty = 1'b1; shifter_idle = 1'b0; cts_in = 1'b1;
    tick(3);
    shifter_idle = 1'b1; cts_in = 1'b0;
    #1;
    chk(load_strobe, 1'b0, "R3 held while CTS high");
    tick(1);
    #1;
    chk(load_strobe, 1'b0, "R3 one edge after CTS low");
    tick(1);
    #1;
    chk(load_strobe, 1'b1, "R3 resume two edges after CTS low");
    shifter_idle = 1'b0;

    for (int a = 0; a < 2; a++)
      for (int e = 0; e < 2; e++) begin
        cts_in = 1'b0; auto_cts_en = a[0]; flow_irq_en = e[0];
        tick(3);
        clear_status();
        cts_in = 1'b1;
        tick(2);
        #1;
        chk(cts_status, 1'b0, "R5 not yet after two edges");
        tick(1);
        #1;
        chk(cts_status, a[0] & e[0], "R5 status on third edge");
        cts_in = 1'b0;
        tick(4);
        #1;
        chk(cts_status, a[0] & e[0], "R6 status sticky");
        clear_status();
        #1;
        chk(cts_status, 1'b0, "R6 cleared by host");
      end

    auto_cts_en = 1'b1; flow_irq_en = 1'b1; cts_in = 1'b0;
    tick(3);
    cts_in = 1'b1;
    tick(2);
    status_clr = 1'b1;
    tick(1);
    status_clr = 1'b0;
    #1;
    chk(cts_status, 1'b1, "R7 set wins over clear");
    clear_status();
    #1;
    chk(cts_status, 1'b0, "R7 later clear takes effect");

    cts_in = 1'b0; fifo_nempty = 1'b1; shifter_idle = 1'b0;
    tick(3);
    cts_in = 1'b1;
    tick(2);
    cts_in = 1'b0;
    tick(3);
    shifter_idle = 1'b1;
    #1;
    chk(load_strobe, 1'b1, "R8 no gap after CTS glitch");
    tick(1);
    shifter_idle = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule